// File: doc/BRIEF.md
# 4-bit ADPCM Nibble Decoder

This block turns a byte stream of packed 4-bit adaptive differential codes into 12-bit unsigned audio samples at a programmable rate. It drives a byte address to an external buffer and expects that byte's contents back combinationally on the same cycle. Each byte supplies two codes, upper nibble first. Each code moves a wrapping predictor by a step. The step comes from a magnitude-indexed scale, and the magnitude then adapts to the code just used.

Software loads a start address and a code-pair count, sets the rate, and writes the control bits to start playback. Every decoded sample is presented with a one-cycle valid strobe. A signed, scaled copy of the sample is also presented for mixing. Two flags show when the remaining count is down to half or has run out. Playback can optionally stop itself when the count reaches zero.

Top module: `adpcm_nibble_dec`

## Requirements
- R1: After reset, sample_o is 2048, pcm_o is 0, and sample_valid_o, playing_o, play_en_o, half_o and end_o are all 0.
- R2: While playing or enabled, a sample tick occurs each time a phase accumulator, advanced by ACC_INC per clock, reaches BASE_CLKS·(16 − rate_i), and the accumulator keeps the remainder. With BASE_CLKS equal to ACC_INC, consecutive samples are exactly 16 − rate_i cycles apart.
- R3: Each byte yields its bits 7:4 as the first code and its bits 3:0 as the second. rd_addr_o advances by 1 (mod 2^16) and len_o decrements by 1 (mod 2^17) only after the second code.
- R4: In a code, bit 3 is the sign and bits 2:0 are the value v. The base step for magnitude m is b = floor(16·1.1^m). The step is b·v[2] + (b>>1)·v[1] + (b>>2)·v[0] + (b>>3). It is subtracted from the predictor when the sign is set and added otherwise, modulo 4096.
- R5: After each code, the magnitude changes by −1 for v of 0 to 3, and by +2, +4, +6 or +8 for v of 4 to 7. The result is clamped to the range 0 to 48.
- R6: On the first tick after playing_o was 0 with the play bit set, playing_o rises. That code is decoded from a predictor of 2048 and a magnitude of 0.
- R7: On a tick where the auto-stop bit (ctrl_i[1]) is set and len_o is 0, the play bit is cleared, playing_o falls and no sample is produced.
- R8: On a tick while the hold bit (ctrl_i[2]) is set, no sample is produced, rd_addr_o and len_o are unchanged, and playing_o takes the value of the play bit. The predictor is kept.
- R9: After each sample, half_o = (len_o ≤ 0x8000). end_o is set when len_o is 0 and stays set until the next load, which clears both flags.
- R10: pcm_o equals (sample_o − 2048)·10 as a signed 16-bit value.
- R11: When the play bit (ctrl_i[0]) is cleared, playing_o falls at the next tick and no further samples are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for ctrl_i |
| ctrl_i | input | 3 | Bit 0 play, bit 1 auto-stop, bit 2 hold |
| rate_i | input | 4 | Rate select r; sample rate scales as 1/(16 − r) |
| load_i | input | 1 | Load start address and count, clear flags |
| load_addr_i | input | 16 | Start byte address |
| load_len_i | input | 17 | Code-pair count |
| rd_addr_o | output | 16 | Current byte address |
| rd_data_i | input | 8 | Byte at rd_addr_o |
| sample_o | output | 12 | Predictor (unsigned sample) |
| pcm_o | output | 16 | Signed scaled sample |
| sample_valid_o | output | 1 | One-cycle strobe per decoded sample |
| playing_o | output | 1 | Playback active |
| play_en_o | output | 1 | Current play bit |
| half_o | output | 1 | Remaining count at or below half |
| end_o | output | 1 | Count reached zero (sticky) |
| len_o | output | 17 | Remaining count |

## Verification
The hardest states to reach from the ports are the two magnitude clamps. The magnitude saturates at 48 only after a run of large codes, and returns to 0 only after dozens of small ones, with no port showing the magnitude directly. The stimulus places one buffer region filled with 0x7F bytes and a following region filled with 0x80 bytes. A single long playback crosses from one region into the other, so the step sizes seen in sample_o climb to the top scale, hold there, and then decay to the bottom one. Auto-stop on a zero count is reached both after a short run and immediately with a count of zero.

// File: rtl/adpcm_dec_pkg.sv
package adpcm_dec_pkg;
  localparam int MAG_W   = 6;
  localparam int MAG_MAX = 48;
  localparam int STEP_W  = 12;

  function automatic logic [10:0] step_base(input logic [MAG_W-1:0] m);
    case (m)
      6'd0: return 11'd16;    6'd1: return 11'd17;    6'd2: return 11'd19;    6'd3: return 11'd21;
      6'd4: return 11'd23;    6'd5: return 11'd25;    6'd6: return 11'd28;    6'd7: return 11'd31;
      6'd8: return 11'd34;    6'd9: return 11'd37;    6'd10: return 11'd41;   6'd11: return 11'd45;
      6'd12: return 11'd50;   6'd13: return 11'd55;   6'd14: return 11'd60;   6'd15: return 11'd66;
      6'd16: return 11'd73;   6'd17: return 11'd80;   6'd18: return 11'd88;   6'd19: return 11'd97;
      6'd20: return 11'd107;  6'd21: return 11'd118;  6'd22: return 11'd130;  6'd23: return 11'd143;
      6'd24: return 11'd157;  6'd25: return 11'd173;  6'd26: return 11'd190;  6'd27: return 11'd209;
      6'd28: return 11'd230;  6'd29: return 11'd253;  6'd30: return 11'd279;  6'd31: return 11'd307;
      6'd32: return 11'd337;  6'd33: return 11'd371;  6'd34: return 11'd408;  6'd35: return 11'd449;
      6'd36: return 11'd494;  6'd37: return 11'd544;  6'd38: return 11'd598;  6'd39: return 11'd658;
      6'd40: return 11'd724;  6'd41: return 11'd796;  6'd42: return 11'd876;  6'd43: return 11'd963;
      6'd44: return 11'd1060; 6'd45: return 11'd1166; 6'd46: return 11'd1282; 6'd47: return 11'd1411;
      default: return 11'd1552;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] step_delta(input logic [MAG_W-1:0] m, input logic [2:0] v);
    logic [STEP_W-1:0] b;
    b = STEP_W'(step_base(m));
    return (v[2] ? b : '0) + (v[1] ? (b >> 1) : '0) + (v[0] ? (b >> 2) : '0) + (b >> 3);
  endfunction

  function automatic logic [MAG_W-1:0] mag_next(input logic [MAG_W-1:0] m, input logic [2:0] v);
    int t;
    t = int'(m) + (v[2] ? 2 * (int'(v[1:0]) + 1) : -1);
    if (t < 0) t = 0;
    if (t > MAG_MAX) t = MAG_MAX;
    return MAG_W'(t);
  endfunction
endpackage

// File: rtl/adpcm_rate_tick.sv
module adpcm_rate_tick #(
  parameter int BASE_CLKS = 672,
  parameter int ACC_INC   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [3:0] rate_i,
  output logic       tick_o
);
  localparam int AW = $clog2(BASE_CLKS * 16 + ACC_INC) + 1;

  logic [AW-1:0] acc_q, sum, thr;

  assign thr    = AW'(BASE_CLKS * (16 - int'(rate_i)));
  assign sum    = acc_q + AW'(ACC_INC);
  assign tick_o = run_i && (sum >= thr);

  // remainder kept so the average period is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (run_i)  acc_q <= tick_o ? sum - thr : sum;
  end

  a_r2_idle_acc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(acc_q));
endmodule

// File: rtl/adpcm_step_calc.sv
module adpcm_step_calc
  import adpcm_dec_pkg::*;
#(
  parameter int PRED_W = 12
) (
  input  logic [PRED_W-1:0] pred_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [3:0]        code_i,
  output logic [PRED_W-1:0] pred_o,
  output logic [MAG_W-1:0]  mag_o
);
  logic [PRED_W-1:0] delta;

  assign delta  = PRED_W'(step_delta(mag_i, code_i[2:0]));
  assign pred_o = code_i[3] ? pred_i - delta : pred_i + delta;  // wraps
  assign mag_o  = mag_next(mag_i, code_i[2:0]);
endmodule

// File: rtl/adpcm_nibble_dec.sv
module adpcm_nibble_dec
  import adpcm_dec_pkg::*;
#(
  parameter int BASE_CLKS = 672,
  parameter int ACC_INC   = 3,
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 17,
  parameter int PRED_W    = 12,
  parameter int PCM_W     = 16,
  parameter int PCM_GAIN  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [2:0]        ctrl_i,
  input  logic [3:0]        rate_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [LEN_W-1:0]  load_len_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic [PRED_W-1:0] sample_o,
  output logic [PCM_W-1:0]  pcm_o,
  output logic              sample_valid_o,
  output logic              playing_o,
  output logic              play_en_o,
  output logic              half_o,
  output logic              end_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [PRED_W-1:0] PRED_MID  = PRED_W'(1) << (PRED_W - 1);
  localparam logic [LEN_W-1:0]  HALF_MARK = LEN_W'(1) << (LEN_W - 2);

  logic              play_q, auto_q, hold_q, playing_q, nib_q;
  logic [PRED_W-1:0] pred_q, pred_base, pred_nxt;
  logic [MAG_W-1:0]  mag_q, mag_base, mag_nxt;
  logic [ADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]  len_q, len_after;
  logic [3:0]        code;
  logic              tick, auto_kill, dec;

  adpcm_rate_tick #(.BASE_CLKS(BASE_CLKS), .ACC_INC(ACC_INC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (playing_q | play_q),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  // fresh start decodes from the midpoint with zero magnitude
  assign pred_base = playing_q ? pred_q : PRED_MID;
  assign mag_base  = playing_q ? mag_q  : '0;
  assign code      = nib_q ? rd_data_i[3:0] : rd_data_i[7:4];
  assign auto_kill = auto_q && (len_q == '0);
  assign dec       = tick && !hold_q && play_q && !auto_kill;
  assign len_after = nib_q ? len_q - 1'b1 : len_q;

  adpcm_step_calc #(.PRED_W(PRED_W)) u_calc (
    .pred_i (pred_base),
    .mag_i  (mag_base),
    .code_i (code),
    .pred_o (pred_nxt),
    .mag_o  (mag_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_q         <= 1'b0;
      auto_q         <= 1'b0;
      hold_q         <= 1'b0;
      playing_q      <= 1'b0;
      nib_q          <= 1'b0;
      pred_q         <= PRED_MID;
      mag_q          <= '0;
      ptr_q          <= '0;
      len_q          <= '0;
      half_o         <= 1'b0;
      end_o          <= 1'b0;
      sample_valid_o <= 1'b0;
    end else begin
      sample_valid_o <= 1'b0;

      if (ctrl_we_i) {hold_q, auto_q, play_q} <= ctrl_i;
      else if (tick && !hold_q && auto_kill) play_q <= 1'b0;

      if (tick) begin
        if (hold_q)                     playing_q <= play_q;
        else if (!play_q || auto_kill)  playing_q <= 1'b0;
        else                            playing_q <= 1'b1;
      end

      if (dec) begin
        pred_q         <= pred_nxt;
        mag_q          <= mag_nxt;
        sample_valid_o <= 1'b1;
      end

      if (load_i) begin
        ptr_q  <= load_addr_i;
        len_q  <= load_len_i;
        nib_q  <= 1'b0;
        half_o <= 1'b0;
        end_o  <= 1'b0;
      end else if (dec) begin
        nib_q  <= ~nib_q;
        len_q  <= len_after;
        if (nib_q) ptr_q <= ptr_q + 1'b1;
        half_o <= (len_after <= HALF_MARK);
        if (len_after == '0) end_o <= 1'b1;
      end
    end
  end

  logic signed [31:0] pcm_full;
  assign pcm_full  = ($signed({20'd0, pred_q}) - $signed({20'd0, PRED_MID})) * PCM_GAIN;
  assign pcm_o     = pcm_full[PCM_W-1:0];
  assign sample_o  = pred_q;
  assign rd_addr_o = ptr_q;
  assign len_o     = len_q;
  assign playing_o = playing_q;
  assign play_en_o = play_q;

  a_r5_mag_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_q <= MAG_W'(MAG_MAX));
  a_r3_ptr_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && nib_q && !load_i) |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r3_ptr_kept_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec && !nib_q && !load_i) |=> $stable(ptr_q) && $stable(len_q));
  a_r8_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && hold_q && !load_i) |=> !sample_valid_o && $stable(ptr_q) && $stable(len_q) && $stable(pred_q));
  a_r7_auto_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !hold_q && auto_kill && !ctrl_we_i) |=> !play_q && !playing_q && !sample_valid_o);
  a_r6_start_needs_play: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(playing_q) |-> $past(play_q));
  a_r11_valid_while_playing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> playing_q);
endmodule

// File: tb/sim_adpcm_nibble_dec.sv
`timescale 1ns/1ps
module sim_adpcm_nibble_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [2:0]  ctrl = '0;
  logic [3:0]  rate = '0;
  logic        load = 1'b0;
  logic [15:0] load_addr = '0;
  logic [16:0] load_len = '0;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic [11:0] sample;
  logic [15:0] pcm;
  logic        valid, playing, play_en, half, endf;
  logic [16:0] len;

  always #2.5 clk = ~clk;

  adpcm_nibble_dec #(.BASE_CLKS(3), .ACC_INC(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_i(ctrl), .rate_i(rate),
    .load_i(load), .load_addr_i(load_addr), .load_len_i(load_len),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .sample_o(sample), .pcm_o(pcm),
    .sample_valid_o(valid), .playing_o(playing), .play_en_o(play_en),
    .half_o(half), .end_o(endf), .len_o(len)
  );

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    if (a[15:8] == 8'h01) return 8'h7F;
    if (a[15:8] == 8'h02) return 8'h80;
    return 8'(a[7:0] * 8'd29 + 8'h5B) ^ a[15:8];
  endfunction
  assign rd_data = mem_at(rd_addr);

  int n_cmp = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent reference model
  int m_pred, m_mag, m_ptr, m_len, m_nib, m_half, m_end;

  function automatic int base_step(input int m);
    return $rtoi($floor(16.0 * $pow(1.1, real'(m))));
  endfunction

  task automatic model_init(input int addr, input int ln);
    m_pred = 2048; m_mag = 0; m_ptr = addr; m_len = ln; m_nib = 0; m_half = 0; m_end = 0;
  endtask

  task automatic model_step();
    int byte_v, c, v, b, d;
    byte_v = int'(mem_at(16'(m_ptr)));
    c = m_nib ? (byte_v & 15) : (byte_v >> 4);
    v = c & 7;
    b = base_step(m_mag);
    d = ((v & 4) ? b : 0) + ((v & 2) ? b / 2 : 0) + ((v & 1) ? b / 4 : 0) + b / 8;
    m_pred = ((c & 8) ? m_pred - d : m_pred + d) & 12'hFFF;
    m_mag = m_mag + ((v < 4) ? -1 : 2 * (v - 3));
    if (m_mag < 0) m_mag = 0;
    if (m_mag > 48) m_mag = 48;
    if (m_nib) begin
      m_ptr = (m_ptr + 1) & 16'hFFFF;
      m_len = (m_len - 1) & 17'h1FFFF;
    end
    m_nib = 1 - m_nib;
    m_half = (m_len <= 32'h8000) ? 1 : 0;
    if (m_len == 0) m_end = 1;
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!valid && cyc < 100);
  endtask

  task automatic write_ctrl(input logic [2:0] c, input logic [3:0] r);
    @(negedge clk);
    ctrl = c; rate = r; ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] a, input logic [16:0] l);
    @(negedge clk);
    load_addr = a; load_len = l; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic check_sample(input int k);
    chk($sformatf("R4 sample %0d", k), int'(sample), m_pred);
    chk("R10 pcm", int'($signed(pcm)), (m_pred - 2048) * 10);
    chk("R3 address", int'(rd_addr), m_ptr);
    chk("R3 length", int'(len), m_len);
    chk("R9 half", int'(half), m_half);
    chk("R9 end", int'(endf), m_end);
  endtask

  task automatic wait_stopped(input string req);
    int guard, extra;
    guard = 0;
    while (playing && guard < 60) begin @(negedge clk); guard++; end
    chk({req, " playing low"}, int'(playing), 0);
    extra = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (valid) extra++; end
    chk({req, " no samples after stop"}, extra, 0);
  endtask

  typedef struct packed {
    logic [3:0]  rate;
    logic        aut;
    logic [15:0] addr;
    logic [16:0] len;
    logic [7:0]  n;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd15, 1'b0, 16'h0010, 17'd5,      8'd20},
    '{4'd12, 1'b0, 16'h8000, 17'h08002,  8'd8},
    '{4'd14, 1'b0, 16'hFFFE, 17'd40,     8'd12},
    '{4'd15, 1'b1, 16'h0100, 17'd3,      8'd12},
    '{4'd15, 1'b0, 16'h01F8, 17'd200,    8'd110},
    '{4'd9,  1'b1, 16'h0400, 17'd0,      8'd4}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int cyc;
    bit stopped;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sample", int'(sample), 2048);
    chk("R1 pcm", int'($signed(pcm)), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 playing", int'(playing), 0);
    chk("R1 flags", int'({play_en, half, endf}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 hold then release, predictor continues from reset values
    do_load(16'h0300, 17'd10);
    write_ctrl(3'b101, 4'd15);
    cyc = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (valid) cyc++; end
    chk("R8 no samples in hold", cyc, 0);
    chk("R8 address held", int'(rd_addr), 16'h0300);
    chk("R8 length held", int'(len), 10);
    chk("R8 playing follows play bit", int'(playing), 1);
    model_init(16'h0300, 10);
    write_ctrl(3'b001, 4'd15);
    if (!valid) wait_valid(cyc);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) wait_valid(cyc);
      model_step();
      check_sample(k);
    end
    write_ctrl(3'b000, 4'd15);
    wait_stopped("R11");

    // vector table
    for (int vi = 0; vi < NV; vi++) begin
      do_load(VECS[vi].addr, VECS[vi].len);
      model_init(int'(VECS[vi].addr), int'(VECS[vi].len));
      write_ctrl({1'b0, VECS[vi].aut, 1'b1}, VECS[vi].rate);
      stopped = 1'b0;
      for (int k = 0; k < int'(VECS[vi].n); k++) begin
        if (VECS[vi].aut && m_len == 0) begin stopped = 1'b1; break; end
        if (k == 0 && valid) cyc = 0;
        else wait_valid(cyc);
        chk("R2 sample strobe", int'(valid), 1);
        if (k > 0) chk("R2 period", cyc, 16 - int'(VECS[vi].rate));
        if (k == 0) chk("R6 playing after start", int'(playing), 1);
        model_step();
        check_sample(k);
      end
      if (stopped) begin
        wait_stopped("R7");
        chk("R7 play bit cleared", int'(play_en), 0);
        chk("R7 length stays zero", int'(len), 0);
      end else begin
        write_ctrl(3'b000, VECS[vi].rate);
        wait_stopped("R11");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule